// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a synchronous DRAM from power-on to an idle state, ready for normal traffic. After reset it holds clock enable and every data-mask line high and keeps a no-operation code on the command pins. It waits out a power-settling interval. It then closes every bank with a single precharge, waits the precharge time, and issues a programmable number of auto-refresh commands, each followed by its recovery interval. It finishes by loading the mode register and waiting the mode-load recovery time. When all of that is done it raises a ready flag, which stays high until the next reset.

All intervals are parameters counted in clock cycles. Each one is the distance from one command's cycle to the next event. At 100 MHz the 500 µs settling interval is 50000 cycles. The mode word is sampled from an input on every clock edge while reset is held low. Before it is driven onto the address pins, every bit outside the latency, burst-type, burst-length and write-mode fields is cleared.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the outputs are CKE high, all DQM bits high and NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), with ready low.
- R2: After reset is released, NOP is held for T_STABLE cycles. The first command, precharge-all, appears on the T_STABLE-th rising edge after release.
- R3: Precharge-all is encoded {cs_n,ras_n,cas_n,we_n} = 4'b0010 with address bit 10 high, and lasts exactly one cycle.
- R4: The first auto-refresh ({cs_n,ras_n,cas_n,we_n} = 4'b0001) appears exactly T_RP cycles after the precharge, with NOP in between.
- R5: Exactly N_REF auto-refresh commands are issued, each T_RFC cycles after the previous one, with NOP in between.
- R6: The mode-register load ({cs_n,ras_n,cas_n,we_n} = 4'b0000) appears T_RFC cycles after the last refresh, with bank address 0. Its address carries mode bits 6:0 and bit 9 unchanged and every other bit zero.
- R7: The mode word is the value on mode_word_i at the last clock edge while reset was low. Changing mode_word_i after reset has no effect on the loaded word.
- R8: ready rises exactly T_MRD cycles after the mode-register load and stays high, with NOP on the command pins, until the next reset.
- R9: CKE and every DQM bit stay high through the whole sequence and afterwards.
- R10: Asserting reset in the middle of the sequence returns the outputs to the R1 state at once, and a later release restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; the mode word is sampled while it is low |
| mode_word_i | input | ADDR_W | Mode-register word to load |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address pins |
| dqm_o | output | DQM_W | Data mask lines |
| ready_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench counts every cycle between commands. A timer off by one shows up as a command one cycle early or late, and a stretched command shows up as a missing NOP. It loads an all-ones mode word to catch a design that passes reserved bits through. It changes the input after reset to catch a design that samples the word late instead of latching it. It also resets in the middle of the refresh phase, which exposes a design that resumes where it stopped or keeps a stale refresh count instead of starting over.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } init_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER    = 3'd0,
        ST_PRE_WAIT = 3'd1,
        ST_REF_WAIT = 3'd2,
        ST_MRS_WAIT = 3'd3,
        ST_READY    = 3'd4
    } init_state_e;

    // Address bit that selects all banks on precharge.
    localparam int unsigned ALL_BANK_BIT = 10;

endpackage

// File: rtl/init_mode_filter.sv
module init_mode_filter #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] raw_i,
    output logic [ADDR_W-1:0] clean_o
);
    // Keep latency/type/length (bits 6:0) and write mode (bit 9); clear the rest.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        if (g < 7 || g == 9) begin : g_keep
            assign clean_o[g] = raw_i[g];
        end else begin : g_clear
            assign clean_o[g] = 1'b0;
        end
    end

    logic unused_raw;
    assign unused_raw = ^raw_i;
endmodule

// File: rtl/init_cmd_pins.sv
module init_cmd_pins
    import sdram_init_pkg::*;
(
    input  init_cmd_e cmd_i,
    output logic      cs_n_o,
    output logic      ras_n_o,
    output logic      cas_n_o,
    output logic      we_n_o
);
    logic [3:0] pins;

    always_comb begin
        unique case (cmd_i)
            CMD_PRE: pins = 4'b0010;
            CMD_REF: pins = 4'b0001;
            CMD_MRS: pins = 4'b0000;
            default: pins = 4'b0111;
        endcase
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned T_STABLE = 50000,
    parameter int unsigned T_RP     = 2,
    parameter int unsigned T_RFC    = 7,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned N_REF    = 8,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BA_W     = 2,
    parameter int unsigned DQM_W    = 9
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQM_W-1:0]  dqm_o,
    output logic              ready_o
);
    localparam int unsigned MAX_A   = (T_STABLE > T_RP) ? T_STABLE : T_RP;
    localparam int unsigned MAX_B   = (T_RFC > T_MRD) ? T_RFC : T_MRD;
    localparam int unsigned CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX) + 1;
    localparam int unsigned REF_W   = $clog2(N_REF + 1);

    typedef struct packed {
        init_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refs;
        init_cmd_e         cmd;
        logic [ADDR_W-1:0] addr;
        logic              ready;
    } seq_t;

    seq_t r_q, r_d;

    logic [ADDR_W-1:0] mode_clean;
    logic [ADDR_W-1:0] mode_q;

    init_mode_filter #(.ADDR_W(ADDR_W)) i_filter (
        .raw_i   (mode_word_i),
        .clean_o (mode_clean)
    );

    // Mode word follows the input on every edge while reset is held low.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            mode_q <= mode_clean;
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.addr = '0;
        if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        unique case (r_q.state)
            ST_POWER: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd                = CMD_PRE;
                    r_d.addr[ALL_BANK_BIT] = 1'b1;
                    r_d.state              = ST_PRE_WAIT;
                    r_d.cnt                = CNT_W'(T_RP - 1);
                end
            end
            ST_PRE_WAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd   = CMD_REF;
                    r_d.refs  = REF_W'(1);
                    r_d.state = ST_REF_WAIT;
                    r_d.cnt   = CNT_W'(T_RFC - 1);
                end
            end
            ST_REF_WAIT: begin
                if (r_q.cnt == '0) begin
                    if (r_q.refs == REF_W'(N_REF)) begin
                        r_d.cmd   = CMD_MRS;
                        r_d.addr  = mode_q;
                        r_d.state = ST_MRS_WAIT;
                        r_d.cnt   = CNT_W'(T_MRD - 1);
                    end else begin
                        r_d.cmd  = CMD_REF;
                        r_d.refs = r_q.refs + 1'b1;
                        r_d.cnt  = CNT_W'(T_RFC - 1);
                    end
                end
            end
            ST_MRS_WAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.ready = 1'b1;
                    r_d.state = ST_READY;
                end
            end
            default: begin
                r_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.state <= ST_POWER;
            r_q.cnt   <= CNT_W'(T_STABLE - 1);
            r_q.refs  <= '0;
            r_q.cmd   <= CMD_NOP;
            r_q.addr  <= '0;
            r_q.ready <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    init_cmd_pins i_pins (
        .cmd_i   (r_q.cmd),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o)
    );

    assign cke_o   = 1'b1;
    assign dqm_o   = '1;
    assign ba_o    = '0;
    assign addr_o  = r_q.addr;
    assign ready_o = r_q.ready;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int unsigned N_REF  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [BA_W-1:0]   ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ready_o
);
    localparam int unsigned CW = $clog2(N_REF + 2);

    logic [3:0] pins;
    logic is_nop, is_pre, is_ref, is_mrs;
    assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    logic          pre_seen_q, mrs_seen_q;
    logic [CW-1:0] ref_cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            pre_seen_q <= 1'b0;
            mrs_seen_q <= 1'b0;
            ref_cnt_q  <= '0;
        end else begin
            if (is_pre) pre_seen_q <= 1'b1;
            if (is_mrs) mrs_seen_q <= 1'b1;
            if (is_ref && ref_cnt_q != '1) ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    a_r3_pre_sets_a10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_pre |-> addr_o[10]);

    a_r4_ref_after_pre: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_ref |-> pre_seen_q);

    a_r5_ref_count_at_mrs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_mrs |-> (ref_cnt_q == CW'(N_REF)));

    a_r6_mrs_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_mrs |-> (ba_o == '0 && addr_o[8:7] == 2'b00 && addr_o[ADDR_W-1:10] == '0));

    a_r8_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ready_o |=> ready_o);

    a_r8_ready_after_mrs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ready_o |-> (mrs_seen_q && is_nop));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .N_REF  (N_REF),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) i_chk (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .ready_o (ready_o)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
    localparam int T_STABLE = 20;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 5;
    localparam int T_MRD    = 4;
    localparam int N_REF    = 8;
    localparam int ADDR_W   = 12;
    localparam int BA_W     = 2;
    localparam int DQM_W    = 9;

    // Step table: expected pins {cs_n,ras_n,cas_n,we_n} and cycles since previous event.
    typedef struct packed {
        logic [3:0] pins;
        logic [7:0] gap;
    } step_t;
    localparam int NSTEP = N_REF + 2;
    localparam step_t STEPS [NSTEP] = '{
        '{4'b0010, 8'(T_STABLE)},
        '{4'b0001, 8'(T_RP)},
        '{4'b0001, 8'(T_RFC)}, '{4'b0001, 8'(T_RFC)}, '{4'b0001, 8'(T_RFC)},
        '{4'b0001, 8'(T_RFC)}, '{4'b0001, 8'(T_RFC)}, '{4'b0001, 8'(T_RFC)},
        '{4'b0001, 8'(T_RFC)},
        '{4'b0000, 8'(T_RFC)}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mode_word = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [DQM_W-1:0]  dqm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .T_STABLE (T_STABLE), .T_RP (T_RP), .T_RFC (T_RFC), .T_MRD (T_MRD),
        .N_REF (N_REF), .ADDR_W (ADDR_W), .BA_W (BA_W), .DQM_W (DQM_W)
    ) i_sdram_init_seq (
        .clk_i (clk), .rst_n_i (rst_n), .mode_word_i (mode_word),
        .cke_o (cke), .cs_n_o (cs_n), .ras_n_o (ras_n), .cas_n_o (cas_n),
        .we_n_o (we_n), .ba_o (ba), .addr_o (addr), .dqm_o (dqm), .ready_o (ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req, input logic exp_ready);
        check(req, {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check(req, {31'd0, ready}, {31'd0, exp_ready});
        check("R9", {22'd0, cke, dqm}, {22'd0, 1'b1, {DQM_W{1'b1}}});
    endtask

    task automatic run_seq(input logic [ADDR_W-1:0] m_rst, input logic [ADDR_W-1:0] m_after,
                           input logic [ADDR_W-1:0] m_exp);
        rst_n     = 1'b0;
        mode_word = m_rst;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_idle("R1", 1'b0);
        end
        rst_n     = 1'b1;
        mode_word = m_after;
        for (int s = 0; s < NSTEP; s++) begin
            string req;
            req = (s == 0) ? "R2" : (s == 1) ? "R4" : (s == NSTEP-1) ? "R6" : "R5";
            for (int c = 1; c < int'(STEPS[s].gap); c++) begin
                @(negedge clk);
                check_idle(req, 1'b0);
            end
            @(negedge clk);
            check(req, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, STEPS[s].pins});
            check("R9", {22'd0, cke, dqm}, {22'd0, 1'b1, {DQM_W{1'b1}}});
            if (s == 0) check("R3", {31'd0, addr[10]}, 32'd1);
            if (s == NSTEP-1) begin
                check("R7", {20'd0, addr}, {20'd0, m_exp});
                check("R6", {30'd0, ba}, 32'd0);
            end
        end
        for (int c = 1; c < T_MRD; c++) begin
            @(negedge clk);
            check_idle("R8", 1'b0);
        end
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check_idle("R8", 1'b1);
        end
    endtask

    initial begin
        // All ones: reserved bits must be cleared (keep 6:0 and 9).
        run_seq(12'hFFF, 12'h000, 12'h27F);
        // Late input change must not alter the loaded word.
        run_seq(12'h032, 12'hFFF, 12'h032);
        // Reset in the middle of refreshing, then a fresh run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (T_STABLE + T_RP + 2 * T_RFC + 1) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check_idle("R10", 1'b0);
        run_seq(12'h230, 12'h005, 12'h230);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule